// File: doc/BRIEF.md
# Complementary Dead-Time Gate Command Generator

This block turns one pulse-width-modulated input into two gate commands for a complementary switch pair: a main switch command and an auxiliary switch command. The two switches are never commanded on together. Each edge of the input switches one output off at once and turns the other on only after a programmable dead time. Delay values are unsigned counts of clock cycles. The leading delay sits between the auxiliary turn-off and the main turn-on. The trailing delay sits between the main turn-off and the auxiliary turn-on.

Each delay has its own active-low zero-voltage sense strobe. When a strobe is asserted while its delay runs, the delay ends at once. The block can be put to sleep through an enable input; while it sleeps, the main command is held low and the auxiliary output is released. A static polarity select chooses how the auxiliary pin is driven. It is either active high, the true complement of the main command, or inverted, for a switch that turns on with a low gate.

The PWM input passes through a synchronizer of two flops. Every output is decoded from one registered state, so nothing reaches the outputs through a chain of logic from the input pins.

Top module: `dt_driver`

## Requirements
- R1: A change on `pwm_in` that is applied between clock edges n and n+1 reaches the output logic after the two-flop synchronizer. The immediate output change is therefore visible after edge n+3.
- R2: On a rising `pwm_in`, the auxiliary switch command turns off after edge n+3. The main output then goes high after edge n+4+`lead_dly`.
- R3: On a falling `pwm_in`, `main_out` goes low after edge n+3. The auxiliary switch command then turns on after edge n+4+`trail_dly`.
- R4: The two delays are independent unsigned values of DLY_W (default 8) bits. A value of zero turns the delayed output on one clock after the immediate change.
- R5: If `lead_sense_n` is low at an edge while the leading delay runs and the input is still high, `main_out` is high after that edge.
- R6: If `trail_sense_n` is low at an edge while the trailing delay runs and the input is still low, the auxiliary switch command is on after that edge.
- R7: A fall of the input during the leading delay cancels the pending main turn-on. The trailing delay then starts from that fall.
- R8: A rise of the input during the trailing delay cancels the pending auxiliary turn-on. The leading delay then starts from that rise.
- R9: `main_out` and the auxiliary switch command are never on in the same cycle. With `aux_oe` high, the auxiliary command is on when `aux_out` differs from `aux_invert`.
- R10: After reset, and from the first edge at which `enable` is sampled low, `main_out`, `aux_out` and `aux_oe` are all 0. They stay 0 whatever `pwm_in` does.
- R11: On the first edge at which `enable` is sampled high after sleep, `aux_oe` rises with both switches off. The leading delay starts if the synchronized input is high; otherwise the trailing delay starts.
- R12: When `aux_oe` is high, `aux_out` equals the auxiliary command if `aux_invert` is 0. It equals the inverted auxiliary command if `aux_invert` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High to run, low to sleep |
| pwm_in | input | 1 | PWM command, synchronized inside |
| lead_dly | input | DLY_W | Dead time in cycles from auxiliary turn-off to main turn-on |
| trail_dly | input | DLY_W | Dead time in cycles from main turn-off to auxiliary turn-on |
| lead_sense_n | input | 1 | Active-low strobe that ends the leading delay |
| trail_sense_n | input | 1 | Active-low strobe that ends the trailing delay |
| aux_invert | input | 1 | 1 drives the auxiliary pin inverted, 0 drives it as the complement of main |
| main_out | output | 1 | Main switch gate command |
| aux_out | output | 1 | Auxiliary pin level |
| aux_oe | output | 1 | Output enable of the auxiliary pin |

## Verification
Rising and falling edges are driven with delays of 3 and 5 cycles and with delays of zero. These separate the counted dead time from the fixed minimum of one cycle, and they show whether the leading and trailing counters are swapped. Pulses shorter than a pending delay show whether a cancelled turn-on still fires. Sense strobes asserted in the middle of a long delay show whether the early end reaches the right output on the next edge. Sleep is entered from the main-on state and left once with the input high and once with it low, so each wake-up path is covered. The polarity select is flipped while the auxiliary switch is on and then kept through a full cycle of the input.

// File: rtl/dt_pkg.sv
// Package: types shared by the dead-time driver modules.
package dt_pkg;
    // Phase of the complementary pair; only ST_MAIN and ST_AUX turn a switch on.
    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_LEAD  = 3'd1,
        ST_MAIN  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_AUX   = 3'd4
    } dt_state_e;
endpackage

// File: rtl/dt_sync.sv
// Module: dt_sync
// Chain of flops that brings an asynchronous level into the clock domain.
// Assumes: STAGES >= 1; reset value 0.
module dt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // first flop samples the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                // later flops pass the level along
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/dt_timer.sv
// Module: dt_timer
// Dead-time counter for one transition. It counts while run is high and
// holds zero otherwise. expired goes high once the count reaches dly, or
// at once when sense_n is low.
// Assumes: run stays low for at least one cycle between two uses.
module dt_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] dly,
    input  logic          sense_n,
    output logic          expired
);
    logic [DW-1:0] cnt;

    // count up to the programmed delay and saturate there; clear when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt < dly)  cnt <= cnt + DW'(1);
    end

    assign expired = run && ((cnt >= dly) || !sense_n);
endmodule

// File: rtl/dt_driver.sv
// Module: dt_driver
// Turns one PWM input into non-overlapping main and auxiliary gate commands.
// A rise turns the auxiliary switch off at once and turns main on after the
// leading delay. A fall turns main off at once and turns the auxiliary switch
// on after the trailing delay. Sense strobes end a delay early. When enable is
// low the block sleeps: main is held low and the auxiliary pin is released.
// Assumes: enable, delays, sense strobes and aux_invert are synchronous to clk.
module dt_driver
    import dt_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] lead_dly,
    input  logic [DLY_W-1:0] trail_dly,
    input  logic             lead_sense_n,
    input  logic             trail_sense_n,
    input  logic             aux_invert,
    output logic             main_out,
    output logic             aux_out,
    output logic             aux_oe
);
    localparam int NTMR = 2;   // index 0: leading delay, index 1: trailing delay

    dt_state_e        state, nxt;
    logic             pwm_s;
    logic             main_on, aux_on;
    logic [DLY_W-1:0] tmr_dly   [NTMR];
    logic             tmr_sense [NTMR];
    logic             tmr_run   [NTMR];
    logic             tmr_exp   [NTMR];

    dt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pwm_in),
        .q_out (pwm_s)
    );

    assign tmr_dly[0]   = lead_dly;
    assign tmr_dly[1]   = trail_dly;
    assign tmr_sense[0] = lead_sense_n;
    assign tmr_sense[1] = trail_sense_n;
    assign tmr_run[0]   = (state == ST_LEAD);
    assign tmr_run[1]   = (state == ST_TRAIL);

    generate
        for (genvar t = 0; t < NTMR; t++) begin : g_tmr
            dt_timer #(.DW(DLY_W)) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .run     (tmr_run[t]),
                .dly     (tmr_dly[t]),
                .sense_n (tmr_sense[t]),
                .expired (tmr_exp[t])
            );
        end
    endgenerate

    // next phase: an input level change overrides any pending delay
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_SLEEP;
        end else begin
            case (state)
                ST_SLEEP: nxt = pwm_s ? ST_LEAD : ST_TRAIL;
                ST_LEAD:  if (!pwm_s)         nxt = ST_TRAIL;
                          else if (tmr_exp[0]) nxt = ST_MAIN;
                ST_MAIN:  if (!pwm_s)         nxt = ST_TRAIL;
                ST_TRAIL: if (pwm_s)          nxt = ST_LEAD;
                          else if (tmr_exp[1]) nxt = ST_AUX;
                ST_AUX:   if (pwm_s)          nxt = ST_LEAD;
                default:  nxt = ST_SLEEP;
            endcase
        end
    end

    // phase register; reset lands in sleep
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= nxt;
    end

    // output decode from the registered phase
    always_comb begin
        main_on  = (state == ST_MAIN);
        aux_on   = (state == ST_AUX);
        aux_oe   = (state != ST_SLEEP);
        main_out = main_on;
        aux_out  = aux_oe && (aux_invert ? !aux_on : aux_on);
    end

    // ---------------- assertions ----------------
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_out && aux_oe && (aux_out != aux_invert)));

    assert_sleep_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!main_out && !aux_oe && !aux_out));

    assert_rise_drops_aux_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && aux_on && pwm_s) |=> !aux_on);

    assert_fall_drops_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && main_on && !pwm_s) |=> !main_out);

    assert_lead_sense_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_LEAD && pwm_s && !lead_sense_n) |=> main_out);

    assert_trail_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_TRAIL && !pwm_s && !trail_sense_n) |=> aux_on);

    assert_wake_both_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_oe) |-> (!main_out && !aux_on));
endmodule

// File: tb/tb_dt_driver.sv
// Scoreboard bench: driver tasks push expected output values tagged with
// the cycle in which they must appear; a monitor pops and compares them.
module tb_dt_driver;
    localparam int DLY_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             pwm_in = 1'b0;
    logic [DLY_W-1:0] lead_dly = 8'd3;
    logic [DLY_W-1:0] trail_dly = 8'd5;
    logic             lead_sense_n = 1'b1;
    logic             trail_sense_n = 1'b1;
    logic             aux_invert = 1'b0;
    logic             main_out, aux_out, aux_oe;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    typedef struct {
        int    c;
        logic  m;
        logic  a;
        logic  oe;
        string tag;
    } exp_t;
    exp_t q[$];

    dt_driver #(.DLY_W(DLY_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_in(pwm_in),
        .lead_dly(lead_dly), .trail_dly(trail_dly),
        .lead_sense_n(lead_sense_n), .trail_sense_n(trail_sense_n),
        .aux_invert(aux_invert),
        .main_out(main_out), .aux_out(aux_out), .aux_oe(aux_oe)
    );

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic ax(input logic cmd);
        return aux_invert ? !cmd : cmd;
    endfunction

    task automatic push(input int c, input logic m, input logic a,
                        input logic oe, input string tag);
        exp_t e;
        e.c = c; e.m = m; e.a = a; e.oe = oe; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: scoreboard compare plus a non-overlap check on every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (main_out && aux_oe && (aux_out != aux_invert)) begin
                bad++;
                $display("FAIL R9 cyc=%0d overlap: main=%b aux=%b oe=%b expected no overlap",
                         cyc, main_out, aux_out, aux_oe);
            end
        end
        while (q.size() > 0 && q[0].c <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (e.c < cyc) begin
                bad++;
                $display("FAIL %s check for cyc=%0d missed (now %0d), expected sampled on time",
                         e.tag, e.c, cyc);
            end else if (main_out !== e.m || aux_out !== e.a || aux_oe !== e.oe) begin
                bad++;
                $display("FAIL %s cyc=%0d actual main=%b aux=%b oe=%b expected main=%b aux=%b oe=%b",
                         e.tag, cyc, main_out, aux_out, aux_oe, e.m, e.a, e.oe);
            end
        end
    end

    // rising edge from the auxiliary-on phase (R1, R2)
    task automatic drive_rise(input string tag);
        int n;
        @(negedge clk);
        pwm_in = 1'b1;
        n = cyc;
        push(n + 2, 0, ax(1), 1, tag);
        push(n + 3, 0, ax(0), 1, tag);
        push(n + 3 + int'(lead_dly), 0, ax(0), 1, tag);
        push(n + 4 + int'(lead_dly), 1, ax(0), 1, tag);
        repeat (int'(lead_dly) + 5) @(negedge clk);
    endtask

    // falling edge from the main-on phase (R1, R3)
    task automatic drive_fall(input string tag);
        int n;
        @(negedge clk);
        pwm_in = 1'b0;
        n = cyc;
        push(n + 2, 1, ax(0), 1, tag);
        push(n + 3, 0, ax(0), 1, tag);
        push(n + 3 + int'(trail_dly), 0, ax(0), 1, tag);
        push(n + 4 + int'(trail_dly), 0, ax(1), 1, tag);
        repeat (int'(trail_dly) + 5) @(negedge clk);
    endtask

    initial begin
        int n;
        // reset state (R10)
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        push(cyc + 1, 0, 0, 0, "R10 reset");
        repeat (3) @(negedge clk);

        // wake with input low: trailing delay first (R11)
        @(negedge clk);
        enable = 1'b1;
        n = cyc;
        push(n + 1, 0, ax(0), 1, "R11 wake low");
        push(n + 1 + int'(trail_dly), 0, ax(0), 1, "R11 wake low");
        push(n + 2 + int'(trail_dly), 0, ax(1), 1, "R11 wake low");
        repeat (int'(trail_dly) + 4) @(negedge clk);

        // basic edges, delays 3 and 5 (R1, R2, R3)
        drive_rise("R2 rise d3");
        drive_fall("R3 fall d5");

        // zero delays: one clock of dead band (R4)
        @(negedge clk);
        lead_dly = 8'd0; trail_dly = 8'd0;
        drive_rise("R4 rise d0");
        drive_fall("R4 fall d0");

        // leading sense ends a 10-cycle delay early (R5)
        @(negedge clk);
        lead_dly = 8'd10; trail_dly = 8'd10;
        pwm_in = 1'b1;
        n = cyc;
        push(n + 3, 0, ax(0), 1, "R5 lead sense");
        push(n + 5, 0, ax(0), 1, "R5 lead sense");
        push(n + 6, 1, ax(0), 1, "R5 lead sense");
        repeat (5) @(negedge clk);
        lead_sense_n = 1'b0;
        @(negedge clk);
        lead_sense_n = 1'b1;
        repeat (3) @(negedge clk);

        // trailing sense ends a 10-cycle delay early (R6)
        @(negedge clk);
        pwm_in = 1'b0;
        n = cyc;
        push(n + 3, 0, ax(0), 1, "R6 trail sense");
        push(n + 5, 0, ax(0), 1, "R6 trail sense");
        push(n + 6, 0, ax(1), 1, "R6 trail sense");
        repeat (5) @(negedge clk);
        trail_sense_n = 1'b0;
        @(negedge clk);
        trail_sense_n = 1'b1;
        repeat (3) @(negedge clk);

        // short high pulse cancels the main turn-on (R7)
        @(negedge clk);
        lead_dly = 8'd10; trail_dly = 8'd5;
        pwm_in = 1'b1;
        n = cyc;
        push(n + 3,  0, ax(0), 1, "R7 cancel main");
        push(n + 7,  0, ax(0), 1, "R7 cancel main");
        push(n + 12, 0, ax(0), 1, "R7 cancel main");
        push(n + 13, 0, ax(1), 1, "R7 cancel main");
        push(n + 14, 0, ax(1), 1, "R7 cancel main");
        repeat (4) @(negedge clk);
        pwm_in = 1'b0;
        repeat (12) @(negedge clk);

        // short low pulse cancels the auxiliary turn-on (R8)
        @(negedge clk);
        lead_dly = 8'd3;
        drive_rise("R2 rise before R8");
        @(negedge clk);
        trail_dly = 8'd10;
        pwm_in = 1'b0;
        n = cyc;
        push(n + 3,  0, ax(0), 1, "R8 cancel aux");
        push(n + 7,  0, ax(0), 1, "R8 cancel aux");
        push(n + 10, 0, ax(0), 1, "R8 cancel aux");
        push(n + 11, 1, ax(0), 1, "R8 cancel aux");
        push(n + 14, 1, ax(0), 1, "R8 cancel aux");
        repeat (4) @(negedge clk);
        pwm_in = 1'b1;
        repeat (12) @(negedge clk);

        // sleep from main-on; input activity ignored (R10)
        @(negedge clk);
        enable = 1'b0;
        n = cyc;
        push(n + 1, 0, 0, 0, "R10 sleep");
        push(n + 6, 0, 0, 0, "R10 sleep input low");
        push(n + 12, 0, 0, 0, "R10 sleep input high");
        repeat (2) @(negedge clk);
        pwm_in = 1'b0;
        repeat (5) @(negedge clk);
        pwm_in = 1'b1;
        repeat (6) @(negedge clk);

        // wake with input high: leading delay first (R11)
        @(negedge clk);
        enable = 1'b1;
        n = cyc;
        push(n + 1, 0, ax(0), 1, "R11 wake high");
        push(n + 1 + int'(lead_dly), 0, ax(0), 1, "R11 wake high");
        push(n + 2 + int'(lead_dly), 1, ax(0), 1, "R11 wake high");
        repeat (int'(lead_dly) + 4) @(negedge clk);

        // polarity select (R12)
        @(negedge clk);
        trail_dly = 8'd4;
        drive_fall("R3 fall before R12");
        @(negedge clk);
        aux_invert = 1'b1;
        push(cyc + 1, 0, 0, 1, "R12 inverted aux on");
        repeat (2) @(negedge clk);
        drive_rise("R12 inverted rise");
        drive_fall("R12 inverted fall");
        @(negedge clk);
        aux_invert = 1'b0;
        push(cyc + 1, 0, 1, 1, "R12 complement aux on");
        repeat (3) @(negedge clk);

        if (q.size() != 0) begin
            bad++;
            total++;
            $display("FAIL scoreboard left %0d items, expected 0", q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired at cyc=%0d, expected finish earlier", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule